// File: doc/BRIEF.md
# FIR Filter Control Register File

This block is the software-facing register file of a streaming FIR filter. It is an AXI4-Lite slave with single-beat reads and writes. It holds a control word and one coefficient word per filter tap. It drives the filter core with an enable level, a one-cycle clear pulse for the core's delay line, a bypass flag, and every coefficient as one flat vector.

Out of reset the filter behaves as a pure wire. Coefficient tap 0 holds the largest positive Q1.15 value and the other taps are zero. The bypass flag is raised, so the core passes its input through unchanged, without the scaling that a 0x7FFF tap would bring. The first write to any coefficient drops the flag for good. The tap count is a parameter. The address decode reserves room for 256 taps.

Top module: `firctl_regfile`

## Requirements
- R1: After reset, enable is 1, clear is 0, bypass is 1, tap 0 holds 0x7FFF, every other tap holds 0, and neither response channel is valid.
- R2: A write is taken only in a cycle where the write address and write data channels are both valid and no write response is pending. `s_awready` and `s_wready` are high together in that cycle only. A lone address or a lone data beat changes nothing.
- R3: Every accepted write gets `s_bresp` = 2'b00, unmapped addresses included. `s_bvalid` rises the cycle after acceptance and stays high until `s_bready` is seen.
- R4: The control word is at byte address 0x00. When `s_wstrb[0]` is set, bit 0 of the data sets enable. Reading it returns enable in bit 0 and zero in all other bits.
- R5: Writing 1 to bit 1 of the control word with `s_wstrb[0]` set makes `filt_clear` high for exactly the one cycle after acceptance. The bit reads back as 0.
- R6: Tap i lives at byte address 0x10 + 4*i. Its signed Q1.15 value sits in data bits 15:0 and appears on `filt_coefs[16*i +: 16]`.
- R7: For a tap, `s_wstrb[0]` enables bits 7:0 and `s_wstrb[1]` enables bits 15:8. `s_wstrb[3:2]` have no effect.
- R8: A tap reads back as its 16-bit value with bit 15 copied into bits 31:16. Upper data bits written to a tap are discarded.
- R9: `filt_bypass` falls on the first accepted write to an existing tap, whatever its strobes. It stays low until reset. Control and unmapped writes leave it alone.
- R10: Reads of unmapped addresses return 0 with `s_rresp` = 2'b00. Unmapped addresses are 0x04 to 0x0C, taps at or above the tap count, and anything past the 256-tap window. Writes to them change no state.
- R11: `s_arready` is high in the cycle a read is taken, which is any cycle with `s_arvalid` high and no read data pending. `s_rdata` and `s_rvalid` then hold steady until `s_rready` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| s_awaddr | input | ADDR_W | Write byte address |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address taken |
| s_wdata | input | 32 | Write data |
| s_wstrb | input | 4 | Write byte enables |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data taken |
| s_bresp | output | 2 | Write response, always OKAY |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response accepted |
| s_araddr | input | ADDR_W | Read byte address |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address taken |
| s_rdata | output | 32 | Read data |
| s_rresp | output | 2 | Read response, always OKAY |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data accepted |
| filt_enable | output | 1 | Filter enable level |
| filt_clear | output | 1 | One-cycle delay-line clear pulse |
| filt_bypass | output | 1 | Pass input through until coefficients are written |
| filt_coefs | output | 16*NTAPS | Tap i in bits 16*i+15 down to 16*i |

## Verification
The assertions assume the manager keeps to the handshake rules: once a valid is raised, it and its payload stay put until the matching ready. They also assume the reset is synchronous, with no bus activity during it. The hold properties on the response channels only make sense under those conditions. The bench keeps within them because its tasks raise each valid at a falling edge and leave it up until they have seen the ready. They also throttle `s_bready` and `s_rready` on purpose so that the hold behaviour is exercised. Random traffic picks addresses from the control word, valid taps, the reserved words and the space above the last tap, with random data and strobes.

// File: rtl/firctl_pkg.sv
`timescale 1ns/1ps
package firctl_pkg;

    localparam int unsigned COEF_W   = 16;
    localparam int unsigned MAX_TAPS = 256;
    localparam logic [31:0] TAP_BASE = 32'h10;
    localparam logic [COEF_W-1:0] UNITY_Q15 = 16'h7FFF;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_CTRL = 2'd1,
        SEL_TAP  = 2'd2
    } sel_e;

    typedef struct packed {
        sel_e       sel;
        logic [7:0] tap;
    } dec_t;

    function automatic dec_t tap_decode(input logic [31:0] a, input int unsigned ntaps);
        dec_t        d;
        logic [31:0] off;
        d.sel = SEL_NONE;
        d.tap = '0;
        off   = a - TAP_BASE;
        if (a[31:2] == 30'd0) begin
            d.sel = SEL_CTRL;
        end else if (a >= TAP_BASE && off[31:2] < 30'(ntaps)) begin
            d.sel = SEL_TAP;
            d.tap = off[9:2];
        end
        return d;
    endfunction

    function automatic logic [31:0] sext_coef(input logic [COEF_W-1:0] c);
        return {{(32-COEF_W){c[COEF_W-1]}}, c};
    endfunction

endpackage

// File: rtl/firctl_wr_chan.sv
`timescale 1ns/1ps
module firctl_wr_chan (
    input  logic clk,
    input  logic rst,
    input  logic awvalid,
    input  logic wvalid,
    input  logic bready,
    output logic awready,
    output logic wready,
    output logic bvalid,
    output logic [1:0] bresp,
    output logic take
);
    logic bvalid_q;

    assign take    = awvalid && wvalid && !bvalid_q;
    assign awready = take;
    assign wready  = take;
    assign bvalid  = bvalid_q;
    assign bresp   = 2'b00;

    always_ff @(posedge clk) begin
        if (rst)         bvalid_q <= 1'b0;
        else if (take)   bvalid_q <= 1'b1;
        else if (bready) bvalid_q <= 1'b0;
    end

    assert_accept_needs_both_R2: assert property (@(posedge clk) disable iff (rst)
        awready |-> (awvalid && wvalid));
    assert_bvalid_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (bvalid && !bready) |=> bvalid);
    assert_resp_after_take_R3: assert property (@(posedge clk) disable iff (rst)
        awready |=> bvalid);
endmodule

// File: rtl/firctl_rd_chan.sv
`timescale 1ns/1ps
module firctl_rd_chan (
    input  logic        clk,
    input  logic        rst,
    input  logic        arvalid,
    input  logic        rready,
    input  logic [31:0] rd_word,
    output logic        arready,
    output logic        rvalid,
    output logic [31:0] rdata,
    output logic [1:0]  rresp
);
    logic        rvalid_q;
    logic [31:0] rdata_q;

    assign arready = arvalid && !rvalid_q;
    assign rvalid  = rvalid_q;
    assign rdata   = rdata_q;
    assign rresp   = 2'b00;

    always_ff @(posedge clk) begin
        if (rst) begin
            rvalid_q <= 1'b0;
            rdata_q  <= '0;
        end else if (arready) begin
            rvalid_q <= 1'b1;
            rdata_q  <= rd_word;
        end else if (rready) begin
            rvalid_q <= 1'b0;
        end
    end

    assert_rdata_hold_R11: assert property (@(posedge clk) disable iff (rst)
        (rvalid && !rready) |=> (rvalid && $stable(rdata)));
    assert_no_accept_pending_R11: assert property (@(posedge clk) disable iff (rst)
        rvalid |-> !arready);
endmodule

// File: rtl/firctl_store.sv
`timescale 1ns/1ps
module firctl_store
    import firctl_pkg::*;
#(
    parameter int unsigned NTAPS = 129
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    wr_en,
    input  logic [31:0]             wr_addr,
    input  logic [COEF_W-1:0]       wr_data,
    input  logic [1:0]              wr_strb,
    input  logic [31:0]             rd_addr,
    output logic [31:0]             rd_word,
    output logic                    enable,
    output logic                    clear,
    output logic                    bypass,
    output logic [NTAPS*COEF_W-1:0] coefs
);
    localparam int unsigned TIW = (NTAPS > 1) ? $clog2(NTAPS) : 1;

    dec_t wd;
    dec_t rdd;
    assign wd  = tap_decode(wr_addr, NTAPS);
    assign rdd = tap_decode(rd_addr, NTAPS);

    logic en_q, clr_q, byp_q;
    logic ctrl_wr, tap_wr;
    assign ctrl_wr = wr_en && (wd.sel == SEL_CTRL) && wr_strb[0];
    assign tap_wr  = wr_en && (wd.sel == SEL_TAP);

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q  <= 1'b1;
            clr_q <= 1'b0;
            byp_q <= 1'b1;
        end else begin
            clr_q <= ctrl_wr && wr_data[1];
            if (ctrl_wr) en_q  <= wr_data[0];
            if (tap_wr)  byp_q <= 1'b0;
        end
    end

    logic [COEF_W-1:0] tap_rd [NTAPS];

    for (genvar g = 0; g < NTAPS; g++) begin : g_tap
        logic [COEF_W-1:0] q;
        logic              hit;
        assign hit = tap_wr && (wd.tap == 8'(g));
        always_ff @(posedge clk) begin
            if (rst) begin
                q <= (g == 0) ? UNITY_Q15 : '0;
            end else if (hit) begin
                if (wr_strb[0]) q[7:0]  <= wr_data[7:0];
                if (wr_strb[1]) q[15:8] <= wr_data[15:8];
            end
        end
        assign tap_rd[g] = q;
        assign coefs[g*COEF_W +: COEF_W] = q;
    end

    always_comb begin
        unique case (rdd.sel)
            SEL_CTRL: rd_word = {31'd0, en_q};
            SEL_TAP:  rd_word = sext_coef(tap_rd[rdd.tap[TIW-1:0]]);
            default:  rd_word = '0;
        endcase
    end

    assign enable = en_q;
    assign clear  = clr_q;
    assign bypass = byp_q;

    initial assert_tap_window_R10: assert (NTAPS >= 1 && NTAPS <= MAX_TAPS);

    assert_clear_single_R5: assert property (@(posedge clk) disable iff (rst)
        clear |=> !clear);
    assert_bypass_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        !bypass |=> !bypass);
    assert_tap_write_drops_bypass_R9: assert property (@(posedge clk) disable iff (rst)
        tap_wr |=> !bypass);
    assert_ctrl_write_keeps_taps_R6: assert property (@(posedge clk) disable iff (rst)
        (!tap_wr) |=> $stable(coefs));
endmodule

// File: rtl/firctl_regfile.sv
`timescale 1ns/1ps
module firctl_regfile
    import firctl_pkg::*;
#(
    parameter int unsigned NTAPS  = 129,
    parameter int unsigned ADDR_W = 12
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [ADDR_W-1:0]       s_awaddr,
    input  logic                    s_awvalid,
    output logic                    s_awready,
    input  logic [31:0]             s_wdata,
    input  logic [3:0]              s_wstrb,
    input  logic                    s_wvalid,
    output logic                    s_wready,
    output logic [1:0]              s_bresp,
    output logic                    s_bvalid,
    input  logic                    s_bready,
    input  logic [ADDR_W-1:0]       s_araddr,
    input  logic                    s_arvalid,
    output logic                    s_arready,
    output logic [31:0]             s_rdata,
    output logic [1:0]              s_rresp,
    output logic                    s_rvalid,
    input  logic                    s_rready,
    output logic                    filt_enable,
    output logic                    filt_clear,
    output logic                    filt_bypass,
    output logic [NTAPS*COEF_W-1:0] filt_coefs
);
    logic        take;
    logic [31:0] rd_word;
    logic        unused_upper;

    assign unused_upper = &{1'b0, s_wdata[31:16], s_wstrb[3:2]};

    firctl_wr_chan u_wr (
        .clk     (clk),
        .rst     (rst),
        .awvalid (s_awvalid),
        .wvalid  (s_wvalid),
        .bready  (s_bready),
        .awready (s_awready),
        .wready  (s_wready),
        .bvalid  (s_bvalid),
        .bresp   (s_bresp),
        .take    (take)
    );

    firctl_rd_chan u_rd (
        .clk     (clk),
        .rst     (rst),
        .arvalid (s_arvalid),
        .rready  (s_rready),
        .rd_word (rd_word),
        .arready (s_arready),
        .rvalid  (s_rvalid),
        .rdata   (s_rdata),
        .rresp   (s_rresp)
    );

    firctl_store #(.NTAPS(NTAPS)) u_store (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (take),
        .wr_addr (32'(s_awaddr)),
        .wr_data (s_wdata[15:0]),
        .wr_strb (s_wstrb[1:0]),
        .rd_addr (32'(s_araddr)),
        .rd_word (rd_word),
        .enable  (filt_enable),
        .clear   (filt_clear),
        .bypass  (filt_bypass),
        .coefs   (filt_coefs)
    );
endmodule

// File: tb/tb_firctl_regfile.sv
`timescale 1ns/1ps
module tb_firctl_regfile;
    localparam int NTAPS  = 129;
    localparam int ADDR_W = 12;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic [ADDR_W-1:0] s_awaddr = '0, s_araddr = '0;
    logic s_awvalid = 0, s_wvalid = 0, s_bready = 0, s_arvalid = 0, s_rready = 0;
    logic [31:0] s_wdata = '0;
    logic [3:0]  s_wstrb = '0;
    logic s_awready, s_wready, s_bvalid, s_arready, s_rvalid;
    logic [1:0] s_bresp, s_rresp;
    logic [31:0] s_rdata;
    logic filt_enable, filt_clear, filt_bypass;
    logic [NTAPS*16-1:0] filt_coefs;

    firctl_regfile #(.NTAPS(NTAPS), .ADDR_W(ADDR_W)) dut (.*);

    int n_chk = 0;
    int n_bad = 0;
    logic [15:0] m_tap [NTAPS];
    logic m_en, m_byp;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    function automatic logic [31:0] exp_read(input logic [31:0] a);
        if (a < 32'h4) return {31'd0, m_en};
        if (a >= 32'h10 && (a - 32'h10) / 4 < NTAPS)
            return {{16{m_tap[(a-32'h10)/4][15]}}, m_tap[(a-32'h10)/4]};
        return 32'd0;
    endfunction

    task automatic model_write(input logic [31:0] a, input logic [31:0] d, input logic [3:0] s);
        if (a < 32'h4) begin
            if (s[0]) m_en = d[0];
        end else if (a >= 32'h10 && (a - 32'h10) / 4 < NTAPS) begin
            if (s[0]) m_tap[(a-32'h10)/4][7:0]  = d[7:0];
            if (s[1]) m_tap[(a-32'h10)/4][15:8] = d[15:8];
            m_byp = 1'b0;
        end
    endtask

    task automatic check_outputs(input string tag);
        int bad_tap = -1;
        for (int i = 0; i < NTAPS; i++)
            if (filt_coefs[i*16 +: 16] !== m_tap[i] && bad_tap < 0) bad_tap = i;
        chk(bad_tap < 0, {tag, " R6 coef vector"}, bad_tap < 0 ? 0 : 32'(filt_coefs[bad_tap*16 +: 16]),
            bad_tap < 0 ? 0 : 32'(m_tap[bad_tap]));
        chk(filt_enable === m_en, {tag, " R4 enable"}, 32'(filt_enable), 32'(m_en));
        chk(filt_bypass === m_byp, {tag, " R9 bypass"}, 32'(filt_bypass), 32'(m_byp));
    endtask

    task automatic do_write(input logic [31:0] a, input logic [31:0] d, input logic [3:0] s,
                            input int hold, output logic clr1, output logic clr2);
        @(negedge clk);
        s_awaddr = a[ADDR_W-1:0]; s_wdata = d; s_wstrb = s;
        s_awvalid = 1; s_wvalid = 1; s_bready = 0;
        #1;
        chk(s_awready === 1 && s_wready === 1, "R2 ready with both valid", 32'({s_awready, s_wready}), 32'd3);
        @(posedge clk);
        model_write(a, d, s);
        @(negedge clk);
        s_awvalid = 0; s_wvalid = 0;
        clr1 = filt_clear;
        chk(s_bvalid === 1 && s_bresp === 2'b00, "R3 bvalid/bresp", 32'({s_bvalid, s_bresp}), 32'h4);
        for (int h = 0; h < hold; h++) begin
            @(negedge clk);
            chk(s_bvalid === 1, "R3 bvalid held", 32'(s_bvalid), 32'd1);
        end
        s_bready = 1;
        @(negedge clk);
        clr2 = filt_clear;
        s_bready = 0;
        chk(s_bvalid === 0, "R3 bvalid drops after bready", 32'(s_bvalid), 32'd0);
    endtask

    task automatic do_read(input logic [31:0] a, input int hold, output logic [31:0] d);
        @(negedge clk);
        s_araddr = a[ADDR_W-1:0]; s_arvalid = 1; s_rready = 0;
        #1;
        chk(s_arready === 1, "R11 arready", 32'(s_arready), 32'd1);
        @(posedge clk);
        @(negedge clk);
        s_arvalid = 0;
        d = s_rdata;
        chk(s_rvalid === 1 && s_rresp === 2'b00, "R11 rvalid/rresp", 32'({s_rvalid, s_rresp}), 32'h4);
        for (int h = 0; h < hold; h++) begin
            @(negedge clk);
            chk(s_rvalid === 1 && s_rdata === d, "R11 rdata held", s_rdata, d);
        end
        s_rready = 1;
        @(negedge clk);
        s_rready = 0;
        chk(s_rvalid === 0, "R11 rvalid drops", 32'(s_rvalid), 32'd0);
    endtask

    task automatic read_check(input logic [31:0] a, input int hold, input string tag);
        logic [31:0] d;
        logic [31:0] e;
        e = exp_read(a);
        do_read(a, hold, d);
        chk(d === e, tag, d, e);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        summary();
    end

    initial begin
        logic c1, c2;
        logic [31:0] a, d;
        logic [3:0] s;
        void'($urandom(32'h5EED_0F1F));
        for (int i = 0; i < NTAPS; i++) m_tap[i] = (i == 0) ? 16'h7FFF : 16'h0;
        m_en = 1; m_byp = 1;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 0;
        @(negedge clk);
        // R1 reset state
        check_outputs("R1 reset");
        chk(filt_clear === 0, "R1 clear low", 32'(filt_clear), 0);
        chk(s_bvalid === 0 && s_rvalid === 0, "R1 no response", 32'({s_bvalid, s_rvalid}), 0);
        read_check(32'h10, 0, "R1 tap0 reads 0x7FFF");
        read_check(32'h14, 0, "R1 tap1 reads 0");
        read_check(32'h0, 0, "R4 ctrl reads enable");

        // R2 lone address / lone data beats do nothing
        @(negedge clk);
        s_awaddr = 12'h1C; s_awvalid = 1;
        for (int k = 0; k < 3; k++) begin
            #1 chk(s_awready === 0 && s_wready === 0, "R2 lone AW not taken", 32'(s_awready), 0);
            @(negedge clk);
        end
        s_awvalid = 0; s_wdata = 32'h1234; s_wstrb = 4'hF; s_wvalid = 1;
        for (int k = 0; k < 3; k++) begin
            #1 chk(s_wready === 0 && s_bvalid === 0, "R2 lone W not taken", 32'(s_wready), 0);
            @(negedge clk);
        end
        s_wvalid = 0;
        check_outputs("R2 after lone beats");

        // R9 control and unmapped writes keep bypass; R10 unmapped writes change nothing
        do_write(32'h8, 32'hFFFF_FFFF, 4'hF, 0, c1, c2);
        do_write(32'h10 + 4*NTAPS, 32'h5555, 4'hF, 1, c1, c2);
        check_outputs("R10 unmapped write");
        // R4 disable, R5 clear pulse
        do_write(32'h0, 32'h2, 4'h1, 0, c1, c2);
        chk(c1 === 1 && c2 === 0, "R5 clear single pulse", 32'({c1, c2}), 32'h2);
        check_outputs("R4 enable off");
        read_check(32'h0, 0, "R5 clear reads back 0");
        do_write(32'h0, 32'h3, 4'h2, 0, c1, c2);
        chk(c1 === 0, "R5 no pulse without strobe0", 32'(c1), 0);
        check_outputs("R4 strobe gated");
        do_write(32'h0, 32'h3, 4'h1, 2, c1, c2);
        chk(c1 === 1 && c2 === 0, "R5 pulse with enable", 32'({c1, c2}), 32'h2);
        read_check(32'h0, 0, "R4 enable readback");

        // R7 strobes, R9 first tap write drops bypass
        do_write(32'h10 + 4*7, 32'hFFFF_FFFF, 4'hC, 0, c1, c2);
        check_outputs("R9 upper-strobe tap write");
        do_write(32'h10 + 4*7, 32'h0000_1234, 4'h3, 0, c1, c2);
        do_write(32'h10 + 4*7, 32'h0000_56FF, 4'h1, 0, c1, c2);
        check_outputs("R7 low byte only");
        read_check(32'h10 + 4*7, 0, "R7 strobe merge 0x12FF");
        // R8 sign extension, upper bits ignored
        do_write(32'h10 + 4*5, 32'hABCD_8001, 4'hF, 0, c1, c2);
        read_check(32'h10 + 4*5, 3, "R8 sign extension");
        do_write(32'h10 + 4*(NTAPS-1), 32'h0000_7ABC, 4'hF, 0, c1, c2);
        read_check(32'h10 + 4*(NTAPS-1), 0, "R6 last tap");
        check_outputs("R6 last tap");
        // R10 unmapped reads
        read_check(32'h4, 0, "R10 reserved word");
        read_check(32'hC, 0, "R10 reserved word");
        read_check(32'h10 + 4*NTAPS, 0, "R10 beyond last tap");
        read_check(32'h40C, 0, "R10 tap 255 slot");
        read_check(32'hFFC, 1, "R10 top of space");

        // random traffic
        for (int n = 0; n < 400; n++) begin
            int kind;
            int cls;
            kind = $urandom % 8;
            cls  = $urandom % 6;
            case (cls)
                0: a = 32'h0;
                1, 2, 3: a = 32'h10 + 4 * ($urandom % NTAPS);
                4: a = 4 * (1 + $urandom % 3);
                default: a = 32'h10 + 4 * (NTAPS + $urandom % (1024 - 4 - NTAPS));
            endcase
            d = $urandom;
            s = 4'($urandom);
            if (kind < 4) begin
                do_write(a, d, s, $urandom % 3, c1, c2);
                chk(c1 === (a == 0 && s[0] && d[1]) && c2 === 0, "R5 random clear", 32'({c1, c2}),
                    32'({(a == 0 && s[0] && d[1]), 1'b0}));
                check_outputs("R6 random");
            end else begin
                read_check(a, $urandom % 3, "R8 random read");
            end
        end
        summary();
    end
endmodule